// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a two-part logical address, a segment number and an offset within that segment, into a flat physical address. The segment descriptors live in ordinary memory as a table, one descriptor per word. A table-origin input gives the word address of entry zero, and a table-size input gives the number of entries. Each descriptor gives the physical start of its segment, the segment length, a present flag and three access rights.

A requester offers one request at a time on a valid/ready port and names the kind of access: load, store or instruction fetch. A segment number outside the table is rejected at once, without touching memory. Any other number causes exactly one descriptor read on the memory port. The descriptor is then checked, and one response comes back. That response carries either the relocated address or a code that names why the access was refused. The table-origin and table-size inputs are sampled when a request is accepted.

Top module: `seg_xlate`

## Requirements
- R1: After reset, req_ready is 1 and rsp_valid and mem_rd are 0.
- R2: A request whose segment number is not less than stlr is answered with code 1 (segment number out of table) in the cycle after acceptance, and no memory read is issued for it.
- R3: A request with a legal segment number raises mem_rd for exactly one cycle, the cycle after acceptance, with mem_addr equal to stbr plus the segment number modulo 2^24.
- R4: A descriptor word is decoded as follows: bit 43 present, bit 42 read right, bit 41 write right, bit 40 execute right, bits 39..16 segment base, and bits 15..0 segment length.
- R5: A descriptor whose present bit is 0 gives code 2 (invalid segment).
- R6: An offset greater than or equal to the segment length gives code 3 (limit).
- R7: Access type 0 (load) needs the read right, 1 (store) needs the write right, and 2 (fetch) needs the execute right. A missing right, or access type 3, gives code 4 (permission).
- R8: When no check fails, the response has code 0, rsp_fault 0, and rsp_pa equal to the base plus the zero-extended offset modulo 2^24.
- R9: When several descriptor checks fail, the code reported is the first that applies in this order: invalid, limit, permission.
- R10: rsp_valid is a single-cycle pulse in the cycle after mem_rvalid is seen. req_ready is 0 from acceptance until that pulse, and is 1 again in the following cycle.
- R11: Whenever the code is nonzero, rsp_fault is 1 and rsp_pa is 0.
- R12: A mem_rvalid that arrives while no descriptor read is pending is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stbr | input | 24 | Word address of descriptor table entry 0 |
| stlr | input | 5 | Number of table entries (0 to 16) |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Block can accept a request |
| req_seg | input | 4 | Segment number |
| req_off | input | 16 | Offset within segment |
| req_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 reserved |
| mem_rd | output | 1 | Descriptor read strobe |
| mem_addr | output | 24 | Descriptor word address |
| mem_rdata | input | 44 | Descriptor word |
| mem_rvalid | input | 1 | Descriptor word valid; allowed from the cycle after mem_rd onward |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Access refused |
| rsp_code | output | 3 | 0 ok, 1 segment number, 2 invalid, 3 limit, 4 permission |
| rsp_pa | output | 24 | Physical address (0 on fault) |

## Verification
A segment-number rejection is due in the cycle after the accepting edge. On a legal segment, mem_rd is due in that same cycle, and the bench returns the descriptor 1 to 4 cycles later; the response is due one cycle after the descriptor arrives. The bench drives on falling edges and samples at every falling edge along the path. It checks that each output is quiet before it is due, that it holds the expected value in exactly the cycle it is due, and that req_ready comes back one cycle later. The expected code and address come from a bench function built on the requirement encodings.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_SEGNUM  = 3'd1,
        FLT_INVALID = 3'd2,
        FLT_LIMIT   = 3'd3,
        FLT_PERM    = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_DONE
    } state_e;

    // rights ordered {read, write, execute}
    function automatic logic right_granted(input logic [2:0] rights, input acc_e kind);
        case (kind)
            ACC_LOAD:  return rights[2];
            ACC_STORE: return rights[1];
            ACC_FETCH: return rights[0];
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/seg_xlate_tbladdr.sv
module seg_xlate_tbladdr #(
    parameter int SEG_W  = 4,
    parameter int MEM_AW = 24
) (
    input  logic [MEM_AW-1:0] origin,
    input  logic [SEG_W-1:0]  seg,
    output logic [MEM_AW-1:0] word_addr
);
    assign word_addr = origin + MEM_AW'(seg);
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk
    import seg_xlate_pkg::*;
#(
    parameter int OFF_W = 16,
    parameter int PA_W  = 24,
    localparam int DESC_W = PA_W + OFF_W + 4
) (
    input  logic [DESC_W-1:0] desc,
    input  logic [OFF_W-1:0]  off,
    input  acc_e              kind,
    output fault_e            code,
    output logic [PA_W-1:0]   pa
);
    localparam int BASE_LO = OFF_W;
    localparam int RWX_LO  = OFF_W + PA_W;
    localparam int PRES    = OFF_W + PA_W + 3;

    logic              present;
    logic [2:0]        rights;
    logic [PA_W-1:0]   base;
    logic [OFF_W-1:0]  length;

    assign present = desc[PRES];
    assign rights  = desc[RWX_LO +: 3];
    assign base    = desc[BASE_LO +: PA_W];
    assign length  = desc[OFF_W-1:0];

    always_comb begin
        if (!present)
            code = FLT_INVALID;
        else if (off >= length)
            code = FLT_LIMIT;
        else if (!right_granted(rights, kind))
            code = FLT_PERM;
        else
            code = FLT_NONE;
    end

    assign pa = base + PA_W'(off);
endmodule

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
    import seg_xlate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_fire,
    input  logic seg_legal,
    input  logic desc_arrived,
    output logic idle,
    output logic rd_strobe,
    output logic desc_take,
    output logic done
);
    state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (req_fire) state_d = seg_legal ? ST_FETCH : ST_DONE;
            ST_FETCH: state_d = ST_WAIT;
            ST_WAIT:  if (desc_arrived) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign idle      = (state_q == ST_IDLE);
    assign rd_strobe = (state_q == ST_FETCH);
    assign desc_take = (state_q == ST_WAIT) && desc_arrived;
    assign done      = (state_q == ST_DONE);
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W  = 4,
    parameter int OFF_W  = 16,
    parameter int PA_W   = 24,
    parameter int MEM_AW = 24,
    localparam int DESC_W = PA_W + OFF_W + 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MEM_AW-1:0] stbr,
    input  logic [SEG_W:0]    stlr,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              mem_rd,
    output logic [MEM_AW-1:0] mem_addr,
    input  logic [DESC_W-1:0] mem_rdata,
    input  logic              mem_rvalid,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [2:0]        rsp_code,
    output logic [PA_W-1:0]   rsp_pa
);
    logic              idle, desc_take, req_fire, seg_legal;
    logic [SEG_W-1:0]  seg_q;
    logic [OFF_W-1:0]  off_q;
    acc_e              acc_q;
    logic [MEM_AW-1:0] origin_q;
    fault_e            code_q, chk_code;
    logic [PA_W-1:0]   pa_q, chk_pa;

    assign req_fire  = req_valid && idle;
    assign seg_legal = {1'b0, req_seg} < stlr;
    assign req_ready = idle;

    seg_xlate_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .req_fire     (req_fire),
        .seg_legal    (seg_legal),
        .desc_arrived (mem_rvalid),
        .idle         (idle),
        .rd_strobe    (mem_rd),
        .desc_take    (desc_take),
        .done         (rsp_valid)
    );

    seg_xlate_tbladdr #(.SEG_W(SEG_W), .MEM_AW(MEM_AW)) u_tbladdr (
        .origin    (origin_q),
        .seg       (seg_q),
        .word_addr (mem_addr)
    );

    seg_xlate_chk #(.OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
        .desc (mem_rdata),
        .off  (off_q),
        .kind (acc_q),
        .code (chk_code),
        .pa   (chk_pa)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q    <= '0;
            off_q    <= '0;
            acc_q    <= ACC_LOAD;
            origin_q <= '0;
            code_q   <= FLT_NONE;
            pa_q     <= '0;
        end else if (req_fire) begin
            seg_q    <= req_seg;
            off_q    <= req_off;
            acc_q    <= acc_e'(req_acc);
            origin_q <= stbr;
            code_q   <= seg_legal ? FLT_NONE : FLT_SEGNUM;
            pa_q     <= '0;
        end else if (desc_take) begin
            code_q <= chk_code;
            pa_q   <= (chk_code == FLT_NONE) ? chk_pa : '0;
        end
    end

    assign rsp_code  = code_q;
    assign rsp_fault = (code_q != FLT_NONE);
    assign rsp_pa    = pa_q;
endmodule

// File: rtl/seg_xlate_sva.sv
module seg_xlate_sva
    import seg_xlate_pkg::*;
#(
    parameter int SEG_W = 4,
    parameter int PA_W  = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [SEG_W-1:0] req_seg,
    input logic [SEG_W:0]   stlr,
    input logic             mem_rd,
    input logic             rsp_valid,
    input logic             rsp_fault,
    input logic [2:0]       rsp_code,
    input logic [PA_W-1:0]  rsp_pa
);
    p_segnum_no_read_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && ({1'b0, req_seg} >= stlr))
        |=> (rsp_valid && rsp_code == FLT_SEGNUM && !mem_rd));

    p_legal_reads_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && ({1'b0, req_seg} < stlr)) |=> (mem_rd && !rsp_valid));

    p_read_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> (!rsp_valid && req_ready));

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_fault_zero_pa_r11: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code != FLT_NONE) |-> (rsp_fault && rsp_pa == '0));
endmodule

bind seg_xlate seg_xlate_sva #(.SEG_W(SEG_W), .PA_W(PA_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_seg   (req_seg),
    .stlr      (stlr),
    .mem_rd    (mem_rd),
    .rsp_valid (rsp_valid),
    .rsp_fault (rsp_fault),
    .rsp_code  (rsp_code),
    .rsp_pa    (rsp_pa)
);

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] stbr = '0;
    logic [4:0]  stlr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_seg = '0;
    logic [15:0] req_off = '0;
    logic [1:0]  req_acc = '0;
    logic        mem_rd;
    logic [23:0] mem_addr;
    logic [43:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;
    logic        rsp_valid, rsp_fault;
    logic [2:0]  rsp_code;
    logic [23:0] rsp_pa;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    seg_xlate dut_i (
        .clk(clk), .rst(rst), .stbr(stbr), .stlr(stlr),
        .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
        .req_off(req_off), .req_acc(req_acc), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_pa(rsp_pa)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [43:0] mk_desc(bit pres, bit r, bit w, bit x,
                                            logic [23:0] base, logic [15:0] len);
        return {pres, r, w, x, base, len};
    endfunction

    // reference model from the requirement encodings
    function automatic int exp_code(logic [3:0] seg, logic [4:0] len_tab,
                                    logic [43:0] d, logic [15:0] off, logic [1:0] acc);
        bit granted;
        if ({1'b0, seg} >= len_tab) return 1;
        if (!d[43]) return 2;
        if (off >= d[15:0]) return 3;
        case (acc)
            2'd0: granted = d[42];
            2'd1: granted = d[41];
            2'd2: granted = d[40];
            default: granted = 1'b0;
        endcase
        return granted ? 0 : 4;
    endfunction

    function automatic string tag_of(int code);
        case (code)
            0: return "R8 R4";
            1: return "R2";
            2: return "R5";
            3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic run_vec(input logic [3:0] seg, input logic [15:0] off, input logic [1:0] acc,
                           input logic [23:0] org, input logic [4:0] len_tab,
                           input logic [43:0] d, input int dly, input string extra);
        int ec;
        logic [23:0] epa;
        string tg;
        ec  = exp_code(seg, len_tab, d, off, acc);
        epa = (ec == 0) ? (d[39:16] + {8'h0, off}) : 24'h0;
        tg  = (extra != "") ? extra : tag_of(ec);
        @(negedge clk);
        check(req_ready == 1'b1, "R10 ready before request", req_ready, 1);
        req_valid = 1'b1; req_seg = seg; req_off = off; req_acc = acc;
        stbr = org; stlr = len_tab;
        @(negedge clk);
        req_valid = 1'b0;
        req_seg = 4'($urandom); req_off = 16'($urandom); req_acc = 2'($urandom);
        stbr = 24'($urandom); stlr = 5'($urandom);
        n_vec = n_vec + 1;
        if (ec == 1) begin
            check(mem_rd == 1'b0, "R2 no read", mem_rd, 0);
        end else begin
            check(mem_rd == 1'b1, "R3 read strobe", mem_rd, 1);
            check(mem_addr == org + {20'h0, seg}, "R3 table address", mem_addr, org + {20'h0, seg});
            check(rsp_valid == 1'b0, "R10 early response", rsp_valid, 0);
            check(req_ready == 1'b0, "R10 busy", req_ready, 0);
            for (int i = 1; i <= dly; i++) begin
                @(negedge clk);
                if (i == 1) check(mem_rd == 1'b0, "R3 single strobe", mem_rd, 0);
                check(rsp_valid == 1'b0, "R10 early response", rsp_valid, 0);
                if (i == dly) begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = d;
                end
            end
            @(negedge clk);
            mem_rvalid = 1'b0;
            mem_rdata  = 44'($urandom) ^ {12'($urandom), 32'h0};
        end
        check(rsp_valid == 1'b1, {tg, " response due"}, rsp_valid, 1);
        check(rsp_code == 3'(ec), {tg, " code"}, rsp_code, ec);
        check(rsp_pa == epa, {tg, " R11 address"}, rsp_pa, epa);
        check(rsp_fault == (ec != 0), {tg, " R11 fault flag"}, rsp_fault, ec != 0);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R10 one-cycle response", rsp_valid, 0);
        check(req_ready == 1'b1, "R10 ready again", req_ready, 1);
    endtask

    initial begin
        void'($urandom(32'h5E61A7));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        check(mem_rd == 1'b0, "R1 mem_rd", mem_rd, 0);

        // directed corners
        run_vec(4'd0, 16'd5, 2'd0, 24'h000100, 5'd0, '0, 1, "R2 empty table");
        run_vec(4'd7, 16'd5, 2'd0, 24'h000100, 5'd7, '0, 1, "R2 seg equals length");
        run_vec(4'd15, 16'd0, 2'd0, 24'h000040, 5'd16, mk_desc(1,1,0,0,24'h123400,16'd10), 2, "R8 last entry");
        run_vec(4'd6, 16'd99, 2'd1, 24'hFFFFFE, 5'd7, mk_desc(1,0,1,0,24'h090000,16'd100), 1, "R3 R8 wrap table and limit-1");
        run_vec(4'd1, 16'd100, 2'd1, 24'h0, 5'd4, mk_desc(1,1,1,1,24'h090000,16'd100), 3, "R6 offset equals length");
        run_vec(4'd1, 16'd0, 2'd0, 24'h0, 5'd4, mk_desc(1,1,1,1,24'h090000,16'd0), 1, "R6 zero length");
        run_vec(4'd2, 16'hFFF0, 2'd2, 24'h0, 5'd4, mk_desc(1,0,0,1,24'hFFFF00,16'hFFFF), 4, "R8 address wraps");
        run_vec(4'd2, 16'd3, 2'd3, 24'h0, 5'd4, mk_desc(1,1,1,1,24'h001000,16'd8), 2, "R7 reserved access");
        run_vec(4'd2, 16'd3, 2'd2, 24'h0, 5'd4, mk_desc(1,1,1,0,24'h001000,16'd8), 1, "R7 no execute");
        run_vec(4'd3, 16'd50, 2'd1, 24'h0, 5'd4, mk_desc(0,0,0,0,24'h001000,16'd8), 1, "R9 invalid over limit");
        run_vec(4'd3, 16'd50, 2'd1, 24'h0, 5'd4, mk_desc(1,1,0,0,24'h001000,16'd8), 1, "R9 limit over permission");

        // stray descriptor return while idle
        @(negedge clk);
        mem_rvalid = 1'b1; mem_rdata = mk_desc(1,1,1,1,24'hABCDEF,16'd1);
        @(negedge clk);
        mem_rvalid = 1'b0;
        check(rsp_valid == 1'b0, "R12 stray rvalid", rsp_valid, 0);
        check(req_ready == 1'b1, "R12 still idle", req_ready, 1);
        run_vec(4'd0, 16'd4, 2'd0, 24'h000200, 5'd1, mk_desc(1,1,0,0,24'h010000,16'd5), 1, "R12 next request clean");

        // constrained random
        for (int k = 0; k < 400; k++) begin
            logic [43:0] d;
            logic [15:0] len, off;
            len = 16'($urandom);
            if ($urandom_range(3) == 0) len = 16'($urandom_range(4));
            case ($urandom_range(3))
                0: off = len;
                1: off = len - 16'd1;
                default: off = 16'($urandom);
            endcase
            d = mk_desc(($urandom_range(7) != 0), 1'($urandom), 1'($urandom), 1'($urandom),
                        24'($urandom), len);
            run_vec(4'($urandom), off, 2'($urandom), 24'($urandom), 5'($urandom_range(16)),
                    d, $urandom_range(1, 4), "");
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule